// File: doc/BRIEF.md
# Compliance Request Responder

This block answers compliance-mode data-object requests that a mailbox delivers to it one 32-bit dword at a time. A request starts with a two-dword object header; the low byte of the dword that follows it is the request code. Once the final request dword arrives, the block picks a response image that matches the code. It then streams that image back one dword at a time under a valid/ready handshake.

Two codes receive an answer. Code 0 is the capability query and code 1 is the status query, and both return fixed contents. Every other code produces an empty response, and so does any request too short to carry a code byte. The block reports how many dwords its response holds. Each response dword packs the response fields little-endian, in field order. The dword count is the packed byte size divided by four, with any remainder dropped. A busy flag covers the span from request acceptance to delivery of the final response dword, and the block takes no request input during that span.

States: `ST_IDLE` waits for the first request dword. `ST_RECV` collects the remaining request dwords. `ST_DISPATCH` latches the response image and its dword count. `ST_SEND` streams the response. The transitions are as follows:
- IDLE goes to RECV on a non-final dword, or straight to DISPATCH on a final one.
- RECV goes to DISPATCH on the final dword.
- DISPATCH goes to SEND when the count is non-zero, and back to IDLE when it is zero.
- SEND goes to IDLE when the final dword is handshaken.

Top module: `cmr_responder`

## Requirements
- R1: While reset is held, and right after it, `busy`=0, `rsp_valid`=0, `req_ready`=1 and `rsp_dw_count`=0.
- R2: The request code is bits [7:0] of request dword index 2, counting from 0. Bits [31:8] of that dword, the contents of all other request dwords and any dwords after index 2 do not affect the response.
- R3: Code 0x00 returns exactly 7 dwords: 0x00001E98, 0x00000007, 0x001C0100, 0x00000003, 0x00000000, 0x00000003, 0x00000000. Field packing: response code byte 0, version byte 1, internal length byte 0x1C, status byte 0, then the 64-bit available and enabled masks, both 0x3.
- R4: Code 0x01 returns exactly 4 dwords: 0x00001E98, 0x00000004, 0x03140101, 0x00000000. The packed size is 18 bytes: response code 1, version 1, length byte 0x14, 32-bit capability 0x3, 16-bit cache size 0 and 8-bit unit 0. The dword count is 18/4 = 4, so the last two bytes are not sent.
- R5: Response dword 0 carries the vendor ID 0x1E98 in bits [15:0] and object type 0 in bits [23:16]. Response dword 1 equals the response length in dwords.
- R6: Any code other than 0x00 and 0x01, including 0x02 to 0x0E and 0xFF, returns no dwords. `rsp_valid` never rises, `busy` is high for exactly one cycle, and `rsp_dw_count` becomes 0.
- R7: A request of one or two dwords carries no code byte and is answered like an unsupported code, as in R6.
- R8: `busy` rises in the cycle after the final request dword is accepted. It stays high until the handshake of the final response dword, and `req_ready` is 0 whenever `busy` is 1.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_data` and `rsp_last` hold their values.
- R10: `rsp_last` is 1 only on the final response dword. After the response, `rsp_dw_count` equals the number of dwords delivered and keeps that value until the next request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request dword present |
| req_ready | output | 1 | Block can accept a request dword |
| req_data | input | 32 | Request dword |
| req_last | input | 1 | Marks the final request dword |
| rsp_valid | output | 1 | Response dword present |
| rsp_ready | input | 1 | Consumer takes the response dword |
| rsp_data | output | 32 | Response dword, little-endian packed fields |
| rsp_last | output | 1 | Marks the final response dword |
| rsp_dw_count | output | 3 | Dword length of the latest response |
| busy | output | 1 | A request has been accepted and its response is not yet fully consumed |

## Verification
The assertions assume that the mailbox holds `req_data` steady while it offers a dword the block refuses, unless it drops `req_valid`. They also assume that the consumer handshakes every response dword eventually.

The bench keeps a fixed dummy request on the input for the whole busy period, so it never breaks the hold rule. It drops that dummy in the cycle of the final response handshake, so the dummy is never taken. Random request lengths, random codes, random filler in the non-code bytes and random backpressure exercise the dispatch, truncation and stall paths inside those rules.

// File: rtl/cmr_pkg.sv
package cmr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_DISPATCH,
        ST_SEND
    } cmr_state_e;

    localparam int DW_W      = 32;
    localparam int IMG_BYTES = 28;
    localparam int IMG_W     = IMG_BYTES * 8;
    localparam int MAX_DW    = IMG_BYTES / 4;
    localparam int CNT_W     = $clog2(MAX_DW + 1);
    localparam int CODE_DW   = 2;

    localparam logic [7:0] CODE_CAPAB  = 8'h00;
    localparam logic [7:0] CODE_STATUS = 8'h01;
    localparam logic [7:0] OBJ_TYPE    = 8'h00;

    localparam int CAPAB_BYTES  = 28;
    localparam int STATUS_BYTES = 18;

    localparam logic [7:0] CAPAB_INNER_LEN  = 8'h1C;
    localparam logic [7:0] STATUS_INNER_LEN = 8'h14;

endpackage

// File: rtl/cmr_req_parser.sv
module cmr_req_parser
    import cmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       take_last,
    input  logic [7:0] low_byte,
    output logic [7:0] code,
    output logic       code_seen
);

    localparam int IDX_W   = $clog2(CODE_DW + 2);
    localparam int IDX_SAT = CODE_DW + 1;

    logic [IDX_W-1:0] idx_q;
    logic [7:0]       code_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            code_q <= 8'hFF;
            seen_q <= 1'b0;
        end else if (take) begin
            if (idx_q == '0) begin
                seen_q <= 1'b0;
            end
            if (idx_q == IDX_W'(CODE_DW)) begin
                code_q <= low_byte;
                seen_q <= 1'b1;
            end
            if (take_last) begin
                idx_q <= '0;
            end else if (idx_q != IDX_W'(IDX_SAT)) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign code      = code_q;
    assign code_seen = seen_q;

endmodule

// File: rtl/cmr_rsp_builder.sv
module cmr_rsp_builder
    import cmr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1E98,
    parameter logic [7:0]  VERSION    = 8'h01,
    parameter logic [63:0] CAPAB_MASK = 64'h3,
    parameter logic [31:0] STAT_CAPAB = 32'h3
) (
    input  logic [7:0]       code,
    input  logic             code_seen,
    output logic [IMG_W-1:0] image,
    output logic [CNT_W-1:0] dw_count
);

    localparam int CAPAB_DW  = CAPAB_BYTES / 4;
    localparam int STATUS_DW = STATUS_BYTES / 4;
    localparam int STATUS_W  = STATUS_BYTES * 8;

    logic [63:0]         hdr_capab;
    logic [63:0]         hdr_status;
    logic [IMG_W-1:0]    img_capab;
    logic [STATUS_W-1:0] img_status;

    assign hdr_capab  = {32'(CAPAB_DW),  8'h00, OBJ_TYPE, VENDOR_ID};
    assign hdr_status = {32'(STATUS_DW), 8'h00, OBJ_TYPE, VENDOR_ID};

    assign img_capab = {CAPAB_MASK, CAPAB_MASK, 8'h00, CAPAB_INNER_LEN,
                        VERSION, 8'h00, hdr_capab};

    assign img_status = {8'h00, 16'h0000, STAT_CAPAB, STATUS_INNER_LEN,
                         VERSION, 8'h01, hdr_status};

    always_comb begin
        image    = '0;
        dw_count = '0;
        if (code_seen) begin
            unique case (code)
                CODE_CAPAB: begin
                    image    = img_capab;
                    dw_count = CNT_W'(CAPAB_DW);
                end
                CODE_STATUS: begin
                    image    = IMG_W'(img_status);
                    dw_count = CNT_W'(STATUS_DW);
                end
                default: begin
                    image    = '0;
                    dw_count = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/cmr_rsp_streamer.sv
module cmr_rsp_streamer
    import cmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IMG_W-1:0] image,
    input  logic [CNT_W-1:0] count_in,
    input  logic             advance,
    output logic [DW_W-1:0]  data,
    output logic             at_last,
    output logic [CNT_W-1:0] count
);

    localparam int SLOTS = 2 ** CNT_W;

    logic [IMG_W-1:0] img_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic [DW_W-1:0]  slot [SLOTS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            img_q <= '0;
            cnt_q <= '0;
            idx_q <= '0;
        end else if (load) begin
            img_q <= image;
            cnt_q <= count_in;
            idx_q <= '0;
        end else if (advance) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < MAX_DW) begin : g_used
            assign slot[g] = img_q[g*DW_W +: DW_W];
        end else begin : g_pad
            assign slot[g] = '0;
        end
    end

    assign data    = slot[idx_q];
    assign at_last = (idx_q == cnt_q - 1'b1);
    assign count   = cnt_q;

endmodule

// File: rtl/cmr_responder.sv
module cmr_responder
    import cmr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID  = 16'h1E98,
    parameter logic [7:0]  VERSION    = 8'h01,
    parameter logic [63:0] CAPAB_MASK = 64'h3,
    parameter logic [31:0] STAT_CAPAB = 32'h3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_data,
    input  logic        req_last,
    output logic        rsp_valid,
    input  logic        rsp_ready,
    output logic [31:0] rsp_data,
    output logic        rsp_last,
    output logic [2:0]  rsp_dw_count,
    output logic        busy
);

    cmr_state_e state_q, state_d;

    logic             take;
    logic             advance;
    logic             load;
    logic [7:0]       code;
    logic             code_seen;
    logic [IMG_W-1:0] image;
    logic [CNT_W-1:0] build_cnt;
    logic [CNT_W-1:0] held_cnt;
    logic             at_last;
    logic [DW_W-1:0]  out_dw;

    assign take    = req_valid && req_ready;
    assign advance = rsp_valid && rsp_ready;
    assign load    = (state_q == ST_DISPATCH);

    cmr_req_parser u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .take_last (req_last),
        .low_byte  (req_data[7:0]),
        .code      (code),
        .code_seen (code_seen)
    );

    cmr_rsp_builder #(
        .VENDOR_ID  (VENDOR_ID),
        .VERSION    (VERSION),
        .CAPAB_MASK (CAPAB_MASK),
        .STAT_CAPAB (STAT_CAPAB)
    ) u_builder (
        .code      (code),
        .code_seen (code_seen),
        .image     (image),
        .dw_count  (build_cnt)
    );

    cmr_rsp_streamer u_streamer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .image    (image),
        .count_in (build_cnt),
        .advance  (advance),
        .data     (out_dw),
        .at_last  (at_last),
        .count    (held_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = req_last ? ST_DISPATCH : ST_RECV;
                end
            end
            ST_RECV: begin
                if (req_valid && req_last) begin
                    state_d = ST_DISPATCH;
                end
            end
            ST_DISPATCH: begin
                state_d = (build_cnt == '0) ? ST_IDLE : ST_SEND;
            end
            ST_SEND: begin
                if (rsp_ready && at_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready    = 1'b0;
        busy         = 1'b0;
        rsp_valid    = 1'b0;
        rsp_last     = 1'b0;
        rsp_data     = '0;
        rsp_dw_count = held_cnt;
        unique case (state_q)
            ST_IDLE, ST_RECV: begin
                req_ready = 1'b1;
            end
            ST_DISPATCH: begin
                busy = 1'b1;
            end
            ST_SEND: begin
                busy      = 1'b1;
                rsp_valid = 1'b1;
                rsp_last  = at_last;
                rsp_data  = out_dw;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cmr_responder_chk.sv
module cmr_responder_chk #(
    parameter logic [15:0] VENDOR_ID = 16'h1E98
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_data,
    input logic        req_last,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_data,
    input logic        rsp_last,
    input logic [2:0]  rsp_dw_count,
    input logic        busy
);

    logic [3:0] sent_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sent_q <= '0;
        end else if (rsp_valid && rsp_ready) begin
            sent_q <= rsp_last ? 4'd0 : sent_q + 4'd1;
        end
    end

    // input rule: a refused request dword stays put unless withdrawn
    a_in_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (!req_valid || ($stable(req_data) && $stable(req_last))));

    a_r8_refuse_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    a_r8_valid_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy);

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_last)));

    a_r10_last_matches_count: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_ready && rsp_last) |-> (sent_q + 4'd1 == {1'b0, rsp_dw_count}));

    a_r10_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (sent_q < {1'b0, rsp_dw_count}));

    a_r6_valid_needs_count: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_dw_count != 3'd0));

    a_r4_count_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_dw_count == 3'd0) || (rsp_dw_count == 3'd4) || (rsp_dw_count == 3'd7));

    a_r5_first_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && sent_q == 4'd0) |-> (rsp_data == {16'h0000, VENDOR_ID}));

    a_r5_second_dword: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && sent_q == 4'd1) |-> (rsp_data == {29'd0, rsp_dw_count}));

endmodule

bind cmr_responder cmr_responder_chk #(.VENDOR_ID(VENDOR_ID)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_data     (req_data),
    .req_last     (req_last),
    .rsp_valid    (rsp_valid),
    .rsp_ready    (rsp_ready),
    .rsp_data     (rsp_data),
    .rsp_last     (rsp_last),
    .rsp_dw_count (rsp_dw_count),
    .busy         (busy)
);

// File: tb/sim_cmr_responder.sv
`timescale 1ns/1ps
module sim_cmr_responder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_data;
    logic        req_last;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [31:0] rsp_data;
    logic        rsp_last;
    logic [2:0]  rsp_dw_count;
    logic        busy;

    int vectors  = 0;
    int mismatch = 0;

    always #5 clk = ~clk;

    cmr_responder u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_data     (req_data),
        .req_last     (req_last),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_data     (rsp_data),
        .rsp_last     (rsp_last),
        .rsp_dw_count (rsp_dw_count),
        .busy         (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            mismatch++;
            $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_count(input int ndw, input logic [7:0] code);
        if (ndw < 3) return 0;
        if (code == 8'h00) return 7;
        if (code == 8'h01) return 4;
        return 0;
    endfunction

    function automatic logic [31:0] exp_dw(input logic [7:0] code, input int i);
        if (code == 8'h00) begin
            case (i)
                0: return 32'h00001E98;
                1: return 32'h00000007;
                2: return 32'h001C0100;
                3: return 32'h00000003;
                5: return 32'h00000003;
                default: return 32'h00000000;
            endcase
        end
        case (i)
            0: return 32'h00001E98;
            1: return 32'h00000004;
            2: return 32'h03140101;
            default: return 32'h00000000;
        endcase
    endfunction

    task automatic run_req(input int ndw, input logic [7:0] code);
        int  cnt;
        int  got;
        bit  done;
        bit  stall;
        bit  rdy;
        logic [31:0] hold_d;
        cnt = exp_count(ndw, code);
        @(negedge clk);
        chk(req_ready == 1'b1 && busy == 1'b0, "R8 idle ready", {31'd0, req_ready}, 32'd1);
        for (int i = 0; i < ndw; i++) begin
            if (i != 0) @(negedge clk);
            req_valid = 1'b1;
            req_data  = $urandom;
            if (i == 2) req_data[7:0] = code;
            req_last  = (i == ndw - 1);
            @(posedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        req_last  = 1'b0;
        #1;
        chk(busy == 1'b1 && req_ready == 1'b0, "R8 busy after accept", {31'd0, busy}, 32'd1);
        chk(rsp_valid == 1'b0, "R6 no valid in dispatch", {31'd0, rsp_valid}, 32'd0);
        if (cnt == 0) begin
            @(negedge clk);
            #1;
            chk(busy == 1'b0, "R6 R7 busy one cycle", {31'd0, busy}, 32'd0);
            chk(rsp_valid == 1'b0, "R6 R7 no response", {31'd0, rsp_valid}, 32'd0);
            chk(rsp_dw_count == 3'd0, "R6 R7 zero count", {29'd0, rsp_dw_count}, 32'd0);
            return;
        end
        got   = 0;
        done  = 1'b0;
        stall = 1'b0;
        hold_d = '0;
        req_valid = 1'b1;
        req_last  = 1'b1;
        req_data  = 32'h0000_0000;
        for (int cyc = 0; cyc < 400 && !done; cyc++) begin
            rdy = ($urandom % 4) != 0;
            rsp_ready = rdy;
            #1;
            if (stall) chk(rsp_data == hold_d && rsp_valid, "R9 stall hold", rsp_data, hold_d);
            stall  = rsp_valid && !rdy;
            hold_d = rsp_data;
            if (rsp_valid) chk(busy && !req_ready, "R8 refuse while busy", {31'd0, req_ready}, 32'd0);
            if (rsp_valid && rdy) begin
                chk(rsp_data == exp_dw(code, got), (code == 0) ? "R3 R5 capab dword" : "R4 R5 status dword",
                    rsp_data, exp_dw(code, got));
                chk(rsp_last == (got == cnt - 1), "R10 last flag", {31'd0, rsp_last},
                    {31'd0, (got == cnt - 1)});
                got++;
                if (rsp_last || got >= cnt) begin
                    done = 1'b1;
                    req_valid = 1'b0;
                    req_last  = 1'b0;
                end
            end
            @(negedge clk);
        end
        rsp_ready = 1'b0;
        #1;
        chk(done, "R10 response completes", {31'd0, done}, 32'd1);
        chk(got == cnt, "R10 dwords delivered", got, cnt);
        chk(busy == 1'b0 && rsp_valid == 1'b0, "R8 busy clears", {31'd0, busy}, 32'd0);
        chk(rsp_dw_count == 3'(cnt), "R10 count held", {29'd0, rsp_dw_count}, cnt);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatch++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, mismatch);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1e98));
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_last  = 1'b0;
        req_data  = '0;
        rsp_ready = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(busy == 1'b0, "R1 reset busy", {31'd0, busy}, 32'd0);
        chk(rsp_valid == 1'b0, "R1 reset valid", {31'd0, rsp_valid}, 32'd0);
        chk(req_ready == 1'b1, "R1 reset ready", {31'd0, req_ready}, 32'd1);
        chk(rsp_dw_count == 3'd0, "R1 reset count", {29'd0, rsp_dw_count}, 32'd0);
        rst_n = 1'b1;

        // directed corners
        run_req(3, 8'h00);   // R3
        run_req(3, 8'h01);   // R4 truncated status
        run_req(3, 8'h02);   // R6
        run_req(3, 8'h0E);   // R6
        run_req(3, 8'hFF);   // R6
        run_req(2, 8'h00);   // R7 short request
        run_req(1, 8'h01);   // R7
        run_req(6, 8'h01);   // R2 trailing dwords ignored
        run_req(4, 8'h00);   // R2

        // constrained random
        for (int n = 0; n < 80; n++) begin
            int ndw;
            logic [7:0] code;
            ndw = 1 + ($urandom % 6);
            case ($urandom % 4)
                0: code = 8'h00;
                1: code = 8'h01;
                2: code = 8'(2 + ($urandom % 13));
                default: code = 8'($urandom);
            endcase
            run_req(ndw, code);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, mismatch);
        $finish;
    end

endmodule